// File: doc/BRIEF.md
# Packed Variable Lane Shifter

This unit performs a logical right shift on every element of a 512-bit vector. Each element has its own shift count. An element can be 16, 32 or 64 bits wide, and the active vector length can be 128, 256 or 512 bits. The count for each lane normally comes from the element in the same position of a count vector. For 32-bit and 64-bit elements, the lowest count element can instead be broadcast to every lane. The bits that the shift vacates are filled with zeros. Any count that is not below the element width clears the lane; the count does not wrap.

An optional per-lane write mask decides what happens to a disabled lane. In merge mode the lane keeps its old destination value, and in zeroing mode it is written with zero. Result bits above the active vector length are always zero.

The unit captures its inputs on a start strobe and registers the result. The result appears one clock later, together with a one-cycle valid pulse. An illegal request raises an error flag in that same cycle and returns an all-zero vector.

Top module: `vshr_unit`

## Requirements
- R1: Each lane is the matching data element shifted right, with zero fill, by its own count. Element size select `esize` uses 0 for 16-bit, 1 for 32-bit and 2 for 64-bit elements. Lane j occupies bits [j*w+w-1 : j*w].
- R2: The whole element-wide count is compared as an unsigned number. A count of 16 or more for 16-bit lanes, 32 or more for 32-bit lanes, or 64 or more for 64-bit lanes makes that lane zero, even when the low count bits are small.
- R3: With `cnt_bcast` set, every lane uses the lowest count element as its count: count bits [31:0] for 32-bit lanes and bits [63:0] for 64-bit lanes.
- R4: With `mask_en` set and `zero_mode` clear, a lane whose bit j of `lane_mask` is 0 keeps element j of `dst_old`.
- R5: With `mask_en` and `zero_mode` both set, a lane whose mask bit is 0 is written with zero.
- R6: With `mask_en` clear, every active lane takes its shifted value whatever `lane_mask` holds.
- R7: Length select `vlen` uses 0 for 128, 1 for 256 and 2 for 512 bits. All result bits at and above the selected length are zero in every mask mode.
- R8: A start seen at a clock edge produces its result and a single-cycle `res_valid` pulse after that edge. Without a start, `res_valid` is low and `res_out` holds its last value.
- R9: Three requests are illegal: broadcast with 16-bit elements, `esize`=3, and `vlen`=3. An illegal start raises `res_err` together with `res_valid`, and `res_out` becomes all zeros.
- R10: A synchronous active-high reset clears `res_out`, `res_valid` and `res_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture request strobe |
| src_data | input | 512 | Data vector to shift |
| src_cnt | input | 512 | Per-lane count vector |
| dst_old | input | 512 | Old destination vector for merging |
| esize | input | 2 | Element size select |
| vlen | input | 2 | Active vector length select |
| lane_mask | input | 32 | Per-lane write mask, bit j for lane j |
| mask_en | input | 1 | Enables the write mask |
| zero_mode | input | 1 | Zeroing (1) or merging (0) for masked lanes |
| cnt_bcast | input | 1 | Use lowest count element for all lanes |
| res_out | output | 512 | Registered result vector |
| res_valid | output | 1 | One-cycle result strobe |
| res_err | output | 1 | Illegal request flag, with res_valid |

## Verification
The hardest cases to reach from the ports are counts whose low bits would give a legal shift but whose upper bits are set. Examples are 0x1_0000_0000 in a 64-bit lane or 0x8000 in a 16-bit lane. Such a count exposes any shifter that looks only at the low log2(width) bits. The stimulus builds count vectors one 16-bit chunk at a time, choosing between small values, exact width limits and fully random values. This puts such mixed counts into wide lanes often. It also places directed lanes at the limit, just above it and far above it. Masks are random in both merge and zeroing mode, and are combined with broadcast and with the shorter vector lengths. This shows that the length clearing takes priority over merging.

// File: rtl/vshr_pkg.sv
package vshr_pkg;

  localparam int VEC_W   = 512;
  localparam int SLICE_W = 64;

  typedef enum logic [1:0] {
    ES_W16 = 2'd0,
    ES_W32 = 2'd1,
    ES_W64 = 2'd2,
    ES_RSV = 2'd3
  } esize_t;

  typedef enum logic [1:0] {
    LEN_128 = 2'd0,
    LEN_256 = 2'd1,
    LEN_512 = 2'd2,
    LEN_RSV = 2'd3
  } vlen_t;

  // Shift with clear: any count at or above the width empties the lane.
  function automatic logic [15:0] shr16(input logic [15:0] v, input logic [15:0] c);
    if (c > 16'd15) return '0;
    return v >> c[3:0];
  endfunction

  function automatic logic [31:0] shr32(input logic [31:0] v, input logic [31:0] c);
    if (c > 32'd31) return '0;
    return v >> c[4:0];
  endfunction

  function automatic logic [63:0] shr64(input logic [63:0] v, input logic [63:0] c);
    if (c > 64'd63) return '0;
    return v >> c[5:0];
  endfunction

endpackage

// File: rtl/vshr_decode.sv
module vshr_decode
  import vshr_pkg::*;
#(
  parameter int NSLICE = 8
) (
  input  logic [1:0]        esize,
  input  logic [1:0]        vlen,
  input  logic              cnt_bcast,
  output logic              illegal,
  output logic [NSLICE-1:0] active
);

  logic size_rsv, len_rsv, bcast_bad;

  assign size_rsv  = (esize == ES_RSV);
  assign len_rsv   = (vlen == LEN_RSV);
  assign bcast_bad = cnt_bcast && (esize == ES_W16);
  assign illegal   = size_rsv || len_rsv || bcast_bad;

  // 128 bits -> 2 slices, 256 -> 4, 512 -> 8
  for (genvar s = 0; s < NSLICE; s++) begin : g_act
    assign active[s] = (32'(s) < (32'd2 << vlen));
  end

endmodule

// File: rtl/vshr_slice.sv
module vshr_slice
  import vshr_pkg::*;
(
  input  logic [SLICE_W-1:0]         d,
  input  logic [SLICE_W-1:0]         c,
  input  logic [SLICE_W-1:0]         old,
  input  logic [SLICE_W-1:0]         bc_cnt,
  input  logic [SLICE_W/16-1:0]      m16,
  input  logic [SLICE_W/32-1:0]      m32,
  input  logic                       m64,
  input  logic [1:0]                 esize,
  input  logic                       mask_on,
  input  logic                       zero_mode,
  input  logic                       bcast,
  input  logic                       active,
  output logic [SLICE_W-1:0]         res
);

  localparam int N16 = SLICE_W / 16;
  localparam int N32 = SLICE_W / 32;

  logic [SLICE_W-1:0] res16, res32, res64;
  logic [SLICE_W-1:0] picked;

  for (genvar k = 0; k < N16; k++) begin : g_w16
    logic [15:0] sh;
    assign sh = shr16(d[k*16 +: 16], c[k*16 +: 16]);
    assign res16[k*16 +: 16] = (!mask_on || m16[k]) ? sh :
                               (zero_mode ? 16'd0 : old[k*16 +: 16]);
  end

  for (genvar k = 0; k < N32; k++) begin : g_w32
    logic [31:0] cnt, sh;
    assign cnt = bcast ? bc_cnt[31:0] : c[k*32 +: 32];
    assign sh  = shr32(d[k*32 +: 32], cnt);
    assign res32[k*32 +: 32] = (!mask_on || m32[k]) ? sh :
                               (zero_mode ? 32'd0 : old[k*32 +: 32]);
  end

  logic [63:0] cnt64, sh64;
  assign cnt64 = bcast ? bc_cnt : c;
  assign sh64  = shr64(d, cnt64);
  assign res64 = (!mask_on || m64) ? sh64 : (zero_mode ? 64'd0 : old);

  always_comb begin
    unique case (esize)
      ES_W16:  picked = res16;
      ES_W32:  picked = res32;
      default: picked = res64;
    endcase
  end

  assign res = active ? picked : '0;

endmodule

// File: rtl/vshr_unit.sv
module vshr_unit
  import vshr_pkg::*;
#(
  parameter int VEC_W_P = VEC_W,
  parameter int MASK_W  = VEC_W_P / 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [VEC_W_P-1:0]  src_data,
  input  logic [VEC_W_P-1:0]  src_cnt,
  input  logic [VEC_W_P-1:0]  dst_old,
  input  logic [1:0]          esize,
  input  logic [1:0]          vlen,
  input  logic [MASK_W-1:0]   lane_mask,
  input  logic                mask_en,
  input  logic                zero_mode,
  input  logic                cnt_bcast,
  output logic [VEC_W_P-1:0]  res_out,
  output logic                res_valid,
  output logic                res_err
);

  localparam int NSLICE = VEC_W_P / SLICE_W;
  localparam int L16    = SLICE_W / 16;
  localparam int L32    = SLICE_W / 32;

  logic                illegal_req;
  logic [NSLICE-1:0]   slice_active;
  logic [VEC_W_P-1:0]  slice_res;
  logic [VEC_W_P-1:0]  next_res;

  vshr_decode #(.NSLICE(NSLICE)) u_dec (
    .esize     (esize),
    .vlen      (vlen),
    .cnt_bcast (cnt_bcast),
    .illegal   (illegal_req),
    .active    (slice_active)
  );

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    vshr_slice u_slice (
      .d         (src_data[s*SLICE_W +: SLICE_W]),
      .c         (src_cnt[s*SLICE_W +: SLICE_W]),
      .old       (dst_old[s*SLICE_W +: SLICE_W]),
      .bc_cnt    (src_cnt[SLICE_W-1:0]),
      .m16       (lane_mask[s*L16 +: L16]),
      .m32       (lane_mask[s*L32 +: L32]),
      .m64       (lane_mask[s]),
      .esize     (esize),
      .mask_on   (mask_en),
      .zero_mode (zero_mode),
      .bcast     (cnt_bcast),
      .active    (slice_active[s]),
      .res       (slice_res[s*SLICE_W +: SLICE_W])
    );
  end

  assign next_res = illegal_req ? '0 : slice_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out   <= '0;
      res_valid <= 1'b0;
      res_err   <= 1'b0;
    end else begin
      res_valid <= start;
      res_err   <= start && illegal_req;
      if (start) res_out <= next_res;
    end
  end

endmodule

// File: rtl/vshr_chk.sv
module vshr_chk #(
  parameter int VEC_W_P = 512,
  parameter int MASK_W  = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [VEC_W_P-1:0] dst_old,
  input logic [1:0]         esize,
  input logic [1:0]         vlen,
  input logic [MASK_W-1:0]  lane_mask,
  input logic               mask_en,
  input logic               zero_mode,
  input logic               cnt_bcast,
  input logic [VEC_W_P-1:0] res_out,
  input logic               res_valid,
  input logic               res_err
);

  p_valid_follows_start_r8: assert property (@(posedge clk) disable iff (rst)
    start |=> res_valid);

  p_valid_single_r8: assert property (@(posedge clk) disable iff (rst)
    !start |=> !res_valid);

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(res_out));

  p_err_zero_r9: assert property (@(posedge clk) disable iff (rst)
    res_err |-> (res_out == '0 && res_valid));

  p_err_bcast16_r9: assert property (@(posedge clk) disable iff (rst)
    (start && cnt_bcast && esize == 2'd0) |=> res_err);

  p_len128_upper_r7: assert property (@(posedge clk) disable iff (rst)
    (start && vlen == 2'd0) |=> (res_out[VEC_W_P-1:128] == '0));

  p_merge_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (start && mask_en && !zero_mode && lane_mask == '0 && vlen == 2'd2 &&
     esize == 2'd1 && !cnt_bcast) |=> (res_out == $past(dst_old)));

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (!res_valid && !res_err && res_out == '0));

endmodule

bind vshr_unit vshr_chk #(.VEC_W_P(VEC_W_P), .MASK_W(MASK_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .dst_old   (dst_old),
  .esize     (esize),
  .vlen      (vlen),
  .lane_mask (lane_mask),
  .mask_en   (mask_en),
  .zero_mode (zero_mode),
  .cnt_bcast (cnt_bcast),
  .res_out   (res_out),
  .res_valid (res_valid),
  .res_err   (res_err)
);

// File: tb/vshr_unit_tb.sv
module vshr_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [511:0] src_data = '0, src_cnt = '0, dst_old = '0;
  logic [1:0]   esize = 2'd0, vlen = 2'd0;
  logic [31:0]  lane_mask = '0;
  logic         mask_en = 1'b0, zero_mode = 1'b0, cnt_bcast = 1'b0;
  logic [511:0] res_out;
  logic         res_valid, res_err;

  int n_checks = 0;
  int n_errors = 0;

  logic [511:0] exp_res = '0;
  bit           exp_val = 1'b0, exp_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vshr_unit u_dut (
    .clk(clk), .rst(rst), .start(start), .src_data(src_data),
    .src_cnt(src_cnt), .dst_old(dst_old), .esize(esize), .vlen(vlen),
    .lane_mask(lane_mask), .mask_en(mask_en), .zero_mode(zero_mode),
    .cnt_bcast(cnt_bcast), .res_out(res_out), .res_valid(res_valid),
    .res_err(res_err)
  );

  // Behavioural reference: walks lanes with integer offsets.
  function automatic logic [511:0] model(input logic [511:0] d, c, o,
      input logic [31:0] m, input int es, ln, input bit um, zm, bc, output bit er);
    int w, vl;
    logic [511:0] wm, v, cc, r, acc;
    er = (es > 2) || (ln > 2) || (bc && es == 0);
    acc = '0;
    if (!er) begin
      w  = 16 << es;
      vl = 128 << ln;
      wm = {512{1'b1}} >> (512 - w);
      for (int j = 0; j < vl / w; j++) begin
        v  = (d >> (j * w)) & wm;
        cc = bc ? (c & wm) : ((c >> (j * w)) & wm);
        if (cc >= 512'(w)) r = '0;
        else               r = v >> cc;
        if (um && !m[j]) r = zm ? '0 : ((o >> (j * w)) & wm);
        acc = acc | (r << (j * w));
      end
    end
    return acc;
  endfunction

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [511:0] rnd_cnt();
    logic [511:0] v;
    int lim [6] = '{15, 16, 31, 32, 63, 64};
    for (int i = 0; i < 32; i++) begin
      case ($urandom % 4)
        0: v[i*16 +: 16] = 16'($urandom % 20);
        1: v[i*16 +: 16] = 16'(lim[$urandom % 6]);
        2: v[i*16 +: 16] = 16'd0;
        default: v[i*16 +: 16] = 16'($urandom);
      endcase
    end
    return v;
  endfunction

  task automatic set_lane(inout logic [511:0] v, input int j, input int w,
                          input logic [63:0] val);
    for (int b = 0; b < w; b++) v[j*w + b] = val[b];
  endtask

  task automatic step(input bit st, input logic [511:0] d, c, o,
      input logic [31:0] m, input logic [1:0] es, ln, input bit um, zm, bc,
      input string tag);
    bit er;
    start = st; src_data = d; src_cnt = c; dst_old = o; lane_mask = m;
    esize = es; vlen = ln; mask_en = um; zero_mode = zm; cnt_bcast = bc;
    if (st) begin
      exp_res = model(d, c, o, m, int'(es), int'(ln), um, zm, bc, er);
      exp_val = 1'b1;
      exp_err = er;
    end else begin
      exp_val = 1'b0;
      exp_err = 1'b0;
    end
    @(negedge clk);
    n_checks++;
    if (res_valid !== exp_val || res_err !== exp_err || res_out !== exp_res) begin
      n_errors++;
      $display("FAIL %s: valid=%0b err=%0b res=%h expected valid=%0b err=%0b res=%h",
               tag, res_valid, res_err, res_out, exp_val, exp_err, exp_res);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    logic [511:0] d, c, o;
    logic [63:0] c16 [8];
    logic [63:0] c32 [8];
    logic [63:0] c64 [8];
    c16 = '{64'd15, 64'd16, 64'd17, 64'hFFFF, 64'h8000, 64'h0010, 64'd0, 64'd1};
    c32 = '{64'd31, 64'd32, 64'd33, 64'hFFFF_FFFF, 64'h8000_0000, 64'h0001_0001, 64'd0, 64'd1};
    c64 = '{64'd63, 64'd64, 64'd65, 64'h1_0000_0000, 64'h8000_0000_0000_0000,
            64'h40, 64'd0, 64'd62};

    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    step(1'b0, '0, '0, '0, '0, 2'd0, 2'd0, 0, 0, 0, "R10 reset");

    // R1: in-range counts, each size
    d = rnd512(); c = '0;
    for (int j = 0; j < 32; j++) set_lane(c, j, 16, 64'(j % 16));
    step(1'b1, d, c, rnd512(), '0, 2'd0, 2'd2, 0, 0, 0, "R1 word");
    d = rnd512(); c = '0;
    for (int j = 0; j < 16; j++) set_lane(c, j, 32, 64'(j * 2));
    step(1'b1, d, c, rnd512(), '0, 2'd1, 2'd2, 0, 0, 0, "R1 dword");
    d = rnd512(); c = '0;
    for (int j = 0; j < 8; j++) set_lane(c, j, 64, 64'(j * 9));
    step(1'b1, d, c, rnd512(), '0, 2'd2, 2'd2, 0, 0, 0, "R1 qword");

    // R2: counts at, just above, and far above the limit
    d = {16{32'hFFFF_FFFF}}; c = '0;
    for (int j = 0; j < 32; j++) set_lane(c, j, 16, c16[j % 8]);
    step(1'b1, d, c, '0, '0, 2'd0, 2'd2, 0, 0, 0, "R2 word limit");
    c = '0;
    for (int j = 0; j < 16; j++) set_lane(c, j, 32, c32[j % 8]);
    step(1'b1, d, c, '0, '0, 2'd1, 2'd2, 0, 0, 0, "R2 dword limit");
    c = '0;
    for (int j = 0; j < 8; j++) set_lane(c, j, 64, c64[j]);
    step(1'b1, d, c, '0, '0, 2'd2, 2'd2, 0, 0, 0, "R2 qword limit");

    // R3: broadcast of lowest count element
    c = rnd512(); c[31:0] = 32'd5;
    step(1'b1, rnd512(), c, '0, '0, 2'd1, 2'd2, 0, 0, 1, "R3 bcast dword");
    c = rnd512(); c[63:0] = 64'd7;
    step(1'b1, rnd512(), c, '0, '0, 2'd2, 2'd2, 0, 0, 1, "R3 bcast qword");
    c = '0; c[63:0] = 64'd64;
    step(1'b1, rnd512(), c, '0, '0, 2'd2, 2'd2, 0, 0, 1, "R3 bcast qword limit");

    // R4 / R5 / R6: masking modes
    step(1'b1, rnd512(), rnd_cnt(), rnd512(), $urandom, 2'd1, 2'd2, 1, 0, 0, "R4 merge");
    step(1'b1, rnd512(), rnd_cnt(), rnd512(), $urandom, 2'd0, 2'd2, 1, 0, 0, "R4 merge word");
    step(1'b1, rnd512(), rnd_cnt(), rnd512(), $urandom, 2'd0, 2'd2, 1, 1, 0, "R5 zeroing");
    step(1'b1, rnd512(), rnd_cnt(), rnd512(), $urandom, 2'd2, 2'd2, 1, 1, 0, "R5 zeroing qword");
    step(1'b1, rnd512(), rnd_cnt(), rnd512(), '0, 2'd1, 2'd2, 0, 1, 0, "R6 mask off");

    // R7: length clearing, even when merging an all-ones old vector
    step(1'b1, rnd512(), rnd_cnt(), {512{1'b1}}, '0, 2'd1, 2'd0, 1, 0, 0, "R7 len128 merge");
    step(1'b1, rnd512(), rnd_cnt(), {512{1'b1}}, $urandom, 2'd0, 2'd1, 1, 0, 0, "R7 len256 word");
    step(1'b1, rnd512(), rnd_cnt(), rnd512(), '1, 2'd2, 2'd1, 0, 0, 0, "R7 len256 qword");

    // R8: idle holds result, valid low
    step(1'b0, rnd512(), rnd_cnt(), rnd512(), $urandom, 2'd1, 2'd2, 0, 0, 0, "R8 idle hold");
    step(1'b0, '0, '0, '0, '0, 2'd0, 2'd0, 0, 0, 0, "R8 idle hold 2");

    // R9: illegal requests
    step(1'b1, rnd512(), rnd_cnt(), rnd512(), '1, 2'd0, 2'd2, 0, 0, 1, "R9 bcast word");
    step(1'b1, rnd512(), rnd_cnt(), rnd512(), '1, 2'd3, 2'd2, 0, 0, 0, "R9 esize rsv");
    step(1'b1, rnd512(), rnd_cnt(), rnd512(), '1, 2'd1, 2'd3, 0, 0, 0, "R9 len rsv");
    step(1'b0, '0, '0, '0, '0, 2'd0, 2'd0, 0, 0, 0, "R9 err clears");

    // Random mix across sizes, lengths and mask modes (R1 R2 R3 R4 R5 R7)
    for (int i = 0; i < 400; i++) begin
      logic [1:0] es, ln;
      bit bc;
      es = 2'($urandom % 3);
      ln = 2'($urandom % 3);
      bc = (es != 2'd0) && ($urandom % 4 == 0);
      step(($urandom % 5) != 0, rnd512(), rnd_cnt(), rnd512(), $urandom, es, ln,
           bit'($urandom % 2), bit'($urandom % 2), bc, "R2 R4 R5 random");
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule